// File: doc/BRIEF.md
# Ping-Pong Frame Capture Engine

This block takes a stream of samples over a valid/ready handshake and writes them into two frame buffers in turn. While one buffer fills, a processor core owns the other one and may read it at the same time. The block tracks how far the current frame has filled. When the last sample of a frame lands, it swaps the roles of the two buffers, restarts the write address at zero in the buffer it now fills, and raises an interrupt that hands the finished buffer to the core.

The core reads the `core_buf` flag to learn which buffer it may read. It clears the interrupt with a one-cycle `irq_ack` pulse. If a second frame finishes before the core has acknowledged the first, a sticky `overrun` flag records the lost hand-off. Capture carries on into the next buffer without a pause. The buffer memories are outside the block. Each has a write-only port that is driven in the same cycle as the sample it stores.

Top module: `pingpong_dma`

## Requirements
- R1: While reset is asserted and right after it is released, `core_buf` is 1, `frame_irq` is 0 and `overrun` is 0. The first accepted sample goes to buffer 0 at address 0.
- R2: Every accepted sample (`s_valid` and `s_ready` high at a clock edge) asserts exactly one write enable in that same cycle. The write goes to the buffer being filled, at an address one above the previous sample's address within the frame, and carries the sample data unchanged.
- R3: After FRAME_LEN samples have been accepted into a buffer, the next accepted sample goes to the other buffer at address 0.
- R4: `core_buf` always names the buffer that is not being filled. Its value is 0 for buffer 0 and 1 for buffer 1. It changes in the cycle after a frame's last sample is accepted. The two write enables are never high together.
- R5: `frame_irq` is high in the cycle after a frame's last sample is accepted.
- R6: Once set, `frame_irq` stays high until an `irq_ack` pulse is seen, and it is low in the cycle after that ack.
- R7: If `irq_ack` arrives in the same cycle as a frame's last sample, `frame_irq` stays high for the new frame and `overrun` is not set.
- R8: If a frame completes while `frame_irq` is still high and no ack comes in that cycle, `overrun` goes high in the next cycle. It stays high until reset, and capture still continues into the new buffer.
- R9: In a cycle with `s_valid` low, no write enable is asserted and the frame position does not move.
- R10: `s_ready` is high in every cycle after reset is released. The block never stalls the stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample valid |
| s_data | input | DATA_W | Sample value |
| s_ready | output | 1 | Sample accepted when high |
| buf0_we | output | 1 | Write enable, buffer 0 |
| buf0_addr | output | ADDR_W | Write address, buffer 0 |
| buf0_wdata | output | DATA_W | Write data, buffer 0 |
| buf1_we | output | 1 | Write enable, buffer 1 |
| buf1_addr | output | ADDR_W | Write address, buffer 1 |
| buf1_wdata | output | DATA_W | Write data, buffer 1 |
| core_buf | output | 1 | Buffer the core may read (0 or 1) |
| frame_irq | output | 1 | Frame-complete interrupt, level |
| irq_ack | input | 1 | One-cycle interrupt acknowledge |
| overrun | output | 1 | Sticky missed-hand-off flag |

## Verification
The hardest cases to reach are the ones where an acknowledge lines up with, or fails to arrive before, a later frame boundary. The bench therefore leaves one interrupt pending across a whole frame. It then lines up the `irq_ack` pulse with the final sample of the next frame to show that the new interrupt wins without an overrun. After that it lets a frame end with nothing acknowledged. Sample gaps are placed inside a frame so that the address counter has to hold across idle cycles. A reset is also asserted partway through a frame, which must send the next sample back to buffer 0, address 0.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;

   typedef enum logic {
      BUF_A = 1'b0,
      BUF_B = 1'b1
   } buf_sel_e;

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/pp_frame_counter.sv
module pp_frame_counter #(
   parameter int FRAME_LEN = 64,
   parameter int ADDR_W    = $clog2(FRAME_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   output logic [ADDR_W-1:0] addr,
   output logic              frame_done
);
   import pp_dma_pkg::*;

   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(FRAME_LEN - 1);

   logic [ADDR_W-1:0] ptr_q;
   logic [ADDR_W-1:0] ptr_nxt;

   assign addr       = ptr_q;
   assign frame_done = accept && (ptr_q == LAST);

   generate
      if (is_pow2(FRAME_LEN)) begin : g_wrap_free
         assign ptr_nxt = ptr_q + ADDR_W'(1);
      end else begin : g_wrap_cmp
         assign ptr_nxt = (ptr_q == LAST) ? '0 : ptr_q + ADDR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      ptr_q <= '0;
      else if (accept) ptr_q <= ptr_nxt;
   end

   // R9
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(ptr_q));

   // R3
   ptr_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> (ptr_q == '0));

endmodule

// File: rtl/pp_swap_ctrl.sv
module pp_swap_ctrl (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  frame_done,
   output pp_dma_pkg::buf_sel_e  fill_buf
);
   import pp_dma_pkg::*;

   buf_sel_e fill_q;

   assign fill_buf = fill_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          fill_q <= BUF_A;
      else if (frame_done) fill_q <= (fill_q == BUF_A) ? BUF_B : BUF_A;
   end

   // R4
   swap_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> (fill_q != $past(fill_q)));

   // R4
   swap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_done |=> $stable(fill_q));

endmodule

// File: rtl/pp_irq_ctrl.sv
module pp_irq_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_done,
   input  logic ack,
   output logic irq,
   output logic overrun
);
   logic irq_q;
   logic ovr_q;

   assign irq     = irq_q;
   assign overrun = ovr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         ovr_q <= 1'b0;
      end else begin
         if (frame_done)  irq_q <= 1'b1;
         else if (ack)    irq_q <= 1'b0;
         if (frame_done && irq_q && !ack) ovr_q <= 1'b1;
      end
   end

   // R5
   irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> irq_q);

   // R6
   irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && ack && !frame_done) |=> !irq_q);

   // R6
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !ack) |=> irq_q);

   // R8
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_q |=> ovr_q);

endmodule

// File: rtl/pp_write_router.sv
module pp_write_router #(
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 6,
   parameter int NUM_BUF = 2
) (
   input  logic                 accept,
   input  pp_dma_pkg::buf_sel_e fill_buf,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    data,
   output logic [NUM_BUF-1:0]   wr_en,
   output logic [ADDR_W-1:0]    wr_addr,
   output logic [DATA_W-1:0]    wr_data
);
   assign wr_addr = addr;
   assign wr_data = data;

   generate
      for (genvar b = 0; b < NUM_BUF; b++) begin : g_port
         assign wr_en[b] = accept && (int'(fill_buf) == b);
      end
   endgenerate

   // R4
   always_comb begin
      one_port_chk: assert ($onehot0(wr_en));
   end

endmodule

// File: rtl/pingpong_dma.sv
module pingpong_dma #(
   parameter int DATA_W    = 16,
   parameter int FRAME_LEN = 64,
   parameter int ADDR_W    = $clog2(FRAME_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_valid,
   input  logic [DATA_W-1:0] s_data,
   output logic              s_ready,
   output logic              buf0_we,
   output logic [ADDR_W-1:0] buf0_addr,
   output logic [DATA_W-1:0] buf0_wdata,
   output logic              buf1_we,
   output logic [ADDR_W-1:0] buf1_addr,
   output logic [DATA_W-1:0] buf1_wdata,
   output logic              core_buf,
   output logic              frame_irq,
   input  logic              irq_ack,
   output logic              overrun
);
   import pp_dma_pkg::*;

   localparam int NUM_BUF = 2;

   generate
      if (FRAME_LEN < 2)
         $fatal(1, "FRAME_LEN must be at least 2");
      if (DATA_W < 1)
         $fatal(1, "DATA_W must be positive");
      if ((1 << ADDR_W) < FRAME_LEN)
         $fatal(1, "ADDR_W too narrow for FRAME_LEN");
   endgenerate

   logic               ready_q;
   logic               accept;
   logic [ADDR_W-1:0]  addr;
   logic               frame_done;
   buf_sel_e           fill_buf;
   logic [NUM_BUF-1:0] wr_en;
   logic [ADDR_W-1:0]  wr_addr;
   logic [DATA_W-1:0]  wr_data;

   always_ff @(posedge clk) begin
      if (!rst_n) ready_q <= 1'b0;
      else        ready_q <= 1'b1;
   end

   assign s_ready = ready_q;
   assign accept  = s_valid && ready_q;

   pp_frame_counter #(.FRAME_LEN(FRAME_LEN), .ADDR_W(ADDR_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .accept(accept),
      .addr(addr), .frame_done(frame_done)
   );

   pp_swap_ctrl u_swap (
      .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .fill_buf(fill_buf)
   );

   pp_irq_ctrl u_irq (
      .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .ack(irq_ack),
      .irq(frame_irq), .overrun(overrun)
   );

   pp_write_router #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_BUF(NUM_BUF)) u_route (
      .accept(accept), .fill_buf(fill_buf), .addr(addr), .data(s_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   assign buf0_we    = wr_en[0];
   assign buf1_we    = wr_en[1];
   assign buf0_addr  = wr_addr;
   assign buf1_addr  = wr_addr;
   assign buf0_wdata = wr_data;
   assign buf1_wdata = wr_data;
   assign core_buf   = ~fill_buf;

   // R10
   ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> s_ready);

   // R4
   core_not_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |-> (core_buf ? buf0_we : buf1_we));

endmodule

// File: tb/tb_pingpong_dma.sv
module tb_pingpong_dma;
   localparam int DW = 16;
   localparam int FL = 8;
   localparam int AW = $clog2(FL);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          s_valid = 1'b0;
   logic [DW-1:0] s_data = '0;
   logic          irq_ack = 1'b0;
   logic          s_ready, buf0_we, buf1_we, core_buf, frame_irq, overrun;
   logic [AW-1:0] buf0_addr, buf1_addr;
   logic [DW-1:0] buf0_wdata, buf1_wdata;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [AW+DW:0] exp_q[$];
   bit      m_fill;
   bit      m_irq;
   bit      m_ovr;
   int      m_cnt;
   logic [DW-1:0] seq;

   always #5 clk = ~clk;

   pingpong_dma #(.DATA_W(DW), .FRAME_LEN(FL)) dut (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
      .s_ready(s_ready), .buf0_we(buf0_we), .buf0_addr(buf0_addr),
      .buf0_wdata(buf0_wdata), .buf1_we(buf1_we), .buf1_addr(buf1_addr),
      .buf1_wdata(buf1_wdata), .core_buf(core_buf), .frame_irq(frame_irq),
      .irq_ack(irq_ack), .overrun(overrun)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic model_reset();
      m_fill = 1'b0; m_irq = 1'b0; m_ovr = 1'b0; m_cnt = 0;
   endtask

   // One cycle: check registered outputs, then drive inputs and advance model.
   task automatic step(input bit v, input bit ack);
      bit wrap;
      @(negedge clk);
      chk(core_buf == ~m_fill, "R4 core_buf", int'(core_buf), int'(~m_fill));
      chk(frame_irq == m_irq, "R6 frame_irq", int'(frame_irq), int'(m_irq));
      chk(overrun == m_ovr, "R8 overrun", int'(overrun), int'(m_ovr));
      chk(s_ready == 1'b1, "R10 s_ready", int'(s_ready), 1);
      s_valid = v;
      irq_ack = ack;
      s_data  = seq;
      if (v) begin
         exp_q.push_back({m_fill, AW'(m_cnt), seq});
         seq = seq + 16'h0101;
      end
      wrap = v && (m_cnt == FL - 1);
      if (v) m_cnt = wrap ? 0 : m_cnt + 1;
      if (wrap && m_irq && !ack) m_ovr = 1'b1;
      if (wrap) begin
         m_fill = ~m_fill;
         m_irq  = 1'b1;
      end else if (ack) begin
         m_irq = 1'b0;
      end
   endtask

   task automatic frame(input int n);
      for (int i = 0; i < n; i++) step(1'b1, 1'b0);
   endtask

   // Scoreboard monitor: compare write ports against queued expectations.
   initial begin
      forever begin
         @(negedge clk);
         #4;
         if (rst_n) begin
            chk(!(buf0_we && buf1_we), "R4 both enables", int'({buf1_we, buf0_we}), 1);
            if (buf0_we || buf1_we) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R9 write without sample", 1, 0);
               end else begin
                  logic [AW+DW:0] e;
                  logic           gb;
                  logic [AW-1:0]  ga;
                  logic [DW-1:0]  gd;
                  e  = exp_q.pop_front();
                  gb = buf1_we;
                  ga = buf1_we ? buf1_addr : buf0_addr;
                  gd = buf1_we ? buf1_wdata : buf0_wdata;
                  chk(gb == e[AW+DW], "R3 target buffer", int'(gb), int'(e[AW+DW]));
                  chk(ga == e[AW+DW-1:DW], "R2 address", int'(ga), int'(e[AW+DW-1:DW]));
                  chk(gd == e[DW-1:0], "R2 data", int'(gd), int'(e[DW-1:0]));
               end
            end else begin
               chk(exp_q.size() == 0, "R2 missing write", 0, exp_q.size());
               exp_q.delete();
            end
         end
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      seq = 16'h1000;
      model_reset();
      repeat (3) @(negedge clk);
      // R1: outputs during reset
      chk(core_buf == 1'b1 && frame_irq == 1'b0 && overrun == 1'b0, "R1 in reset",
          int'({core_buf, frame_irq, overrun}), 4);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: state right after reset
      chk(core_buf == 1'b1, "R1 core_buf", int'(core_buf), 1);
      chk(frame_irq == 1'b0 && overrun == 1'b0, "R1 no irq", int'({frame_irq, overrun}), 0);

      // R2 R3 R5: first frame into buffer 0, irq afterwards
      frame(FL);
      step(1'b0, 1'b0);
      chk(frame_irq == 1'b1 && core_buf == 1'b0, "R5 irq after frame",
          int'({frame_irq, core_buf}), 2);
      // R6: held until ack
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      step(1'b0, 1'b1);
      step(1'b0, 1'b0);
      chk(frame_irq == 1'b0, "R6 ack clears", int'(frame_irq), 0);

      // R9: frame with gaps into buffer 1
      for (int i = 0; i < FL; i++) begin
         step(1'b1, 1'b0);
         step(1'b0, 1'b0);
         step(1'b0, 1'b0);
      end
      chk(core_buf == 1'b1 && frame_irq == 1'b1, "R9 gapped frame done",
          int'({core_buf, frame_irq}), 3);

      // R7: irq left pending, ack coincides with last sample of next frame
      frame(FL - 1);
      step(1'b1, 1'b1);
      step(1'b0, 1'b0);
      chk(frame_irq == 1'b1 && overrun == 1'b0, "R7 ack with completion",
          int'({frame_irq, overrun}), 2);

      // R8: next frame completes with irq still pending
      frame(FL);
      step(1'b0, 1'b0);
      chk(overrun == 1'b1, "R8 overrun set", int'(overrun), 1);
      step(1'b0, 1'b1);
      frame(FL);
      frame(3);
      step(1'b0, 1'b1);
      step(1'b0, 1'b0);
      chk(overrun == 1'b1, "R8 overrun sticky", int'(overrun), 1);

      // R1: reset mid-frame restarts at buffer 0 address 0
      @(negedge clk);
      rst_n = 1'b0;
      s_valid = 1'b0;
      irq_ack = 1'b0;
      exp_q.delete();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      step(1'b1, 1'b0);
      frame(FL - 1);
      frame(2);
      step(1'b0, 1'b0);
      step(1'b0, 1'b0);
      chk(exp_q.size() == 0, "R2 all writes seen", exp_q.size(), 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule